// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART channel's serial engines, its CPU-side data and status paths and the two serial pins. A 2-bit mode field selects one of four routings:

- **Normal:** the transmitter and receiver run independently.
- **Automatic echo:** incoming bits are re-sent on the transmit pin.
- **Local loopback:** the transmitter feeds the receiver inside the chip.
- **Remote loopback:** incoming bits are echoed back and the CPU never sees them.

For each mode the router chooses:

- which bit-clock tick drives each engine;
- what reaches the TxD pin and the receiver input;
- which CPU paths and status flags are allowed through.

In the echo modes the router re-clocks the received stream itself. It samples RxD on each receive bit-center tick and drives TxD from that register. Parity bits, stop bits and breaks therefore go out exactly as they arrived, one tick late.

A mode change acts in the same cycle it is applied, even in the middle of a character, with one exception. Suppose an echo mode is left during the bit time that follows a stop-bit sample, and the transmitter is enabled. The echo routing then stays in force until that stop bit has been sent out in full.

The bit clocks are single-cycle enable ticks in the `clk` domain.

Top module: `uart_mode_router`

## Requirements
- R1: With mode 2'b00 (normal), TxD equals the transmitter serial output and the receiver input equals RxD. Each engine gets its own tick, and every gate output (CPU receive, CPU transmit, transmitter status, receiver error, parity/framing check) is 1.
- R2: In modes 2'b01 and 2'b11, a register loads RxD on each cycle where the receive tick is high and holds its value otherwise. TxD shows that register from the cycle after the tick. The transmit tick output equals the receive tick input.
- R3: In mode 2'b01 (automatic echo), the CPU transmit gate and the transmitter status gate are 0. The CPU receive, receiver error and check gates are 1.
- R4: In mode 2'b10 (local loopback), TxD is 1 and the receiver input equals the transmitter serial output. Both tick outputs equal the transmit tick input, all gates are 1, and RxD has no effect on any output.
- R5: In mode 2'b11 (remote loopback), the receiver input is RxD and the receive tick output is the receive tick input. All five gates are 0.
- R6: In either echo mode, RxD held low over several receive ticks (a break) keeps TxD low for every one of those bit times.
- R7: A change of the mode field reaches every output in the same cycle, without waiting for a clock edge or a tick.
- R8: A stop-sample pulse counts only when it coincides with a receive tick. Suppose, in an echo mode with transmitter enable 1, such a tick occurs. If the mode field then leaves the echo modes before the next receive tick, all outputs keep the echo routing until that next tick. From the following cycle they follow the new mode.
- R9: If transmitter enable was 0 at the stop-sample tick, or no stop sample occurred, leaving an echo mode acts at once.
- R10: During and after reset the echo register holds 1, so TxD is 1 in an echo mode until the first receive tick, and no deferred exit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Channel mode: 00 normal, 01 auto echo, 10 local loop, 11 remote loop |
| rxd_i | input | 1 | Serial receive pin |
| tx_ser_i | input | 1 | Serial output of the transmitter engine |
| rx_tick_i | input | 1 | Receive bit-center tick |
| tx_tick_i | input | 1 | Transmit bit tick |
| tx_en_i | input | 1 | Transmitter enabled flag |
| rx_stop_i | input | 1 | Receiver has sampled a stop bit (valid with rx_tick_i) |
| txd_o | output | 1 | Serial transmit pin |
| rx_ser_o | output | 1 | Serial input to the receiver engine |
| rx_tick_o | output | 1 | Tick routed to the receiver |
| tx_tick_o | output | 1 | Tick routed to the transmitter |
| cpu_rx_en_o | output | 1 | Gate: received data may reach the CPU |
| cpu_tx_en_o | output | 1 | Gate: CPU may load the transmitter |
| tx_stat_en_o | output | 1 | Gate: transmitter ready/empty flags may be active |
| rx_err_en_o | output | 1 | Gate: receiver error flags may be active |
| rx_chk_en_o | output | 1 | Gate: receiver checks parity and framing |

## Verification
The assertions take two things for granted:

- `rx_stop_i` is only meaningful in a cycle where `rx_tick_i` is high.
- Ticks are single-cycle pulses sampled at the rising clock edge.

The stimulus drives every input on the falling edge. It raises the stop pulse only together with a receive tick. It keeps RxD at 1 whenever a tick falls inside the table-driven routing vectors, so the echo register stays at its known idle value there. Echo timing, breaks and deferred exits are then exercised with directed sequences that respect the same rules.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_NORMAL = 2'b00,
      MODE_ECHO   = 2'b01,
      MODE_LOCAL  = 2'b10,
      MODE_REMOTE = 2'b11
   } chan_mode_e;

   // Both modes that re-send received bits on the transmit pin
   function automatic logic is_echo(chan_mode_e m);
      return (m == MODE_ECHO) || (m == MODE_REMOTE);
   endfunction
endpackage

// File: rtl/urt_echo_retimer.sv
module urt_echo_retimer #(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic din_i,
   output logic dout_o
);
   logic bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= IDLE_LEVEL;
      else if (tick_i) bit_q <= din_i;
   end

   assign dout_o = bit_q;

   // R2: register follows the line only at a bit-center tick
   a_r2_echo_samples: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> (dout_o == $past(din_i)));
   a_r2_echo_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(dout_o));
endmodule

// File: rtl/urt_exit_holder.sv
module urt_exit_holder
   import uart_route_pkg::*;
#(
   parameter int DEFER_EXIT = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  chan_mode_e mode_i,
   input  logic       rx_tick_i,
   input  logic       stop_i,
   input  logic       tx_en_i,
   output chan_mode_e eff_mode_o
);
   generate
      if ((DEFER_EXIT != 0) && (DEFER_EXIT != 1)) begin : g_bad_param
         $error("DEFER_EXIT must be 0 or 1");
      end

      if (DEFER_EXIT == 1) begin : g_defer
         logic       hold_q;
         chan_mode_e held_q;

         // Mode field applies at once unless an echo mode is being left
         // inside the bit time after a counted stop sample.
         assign eff_mode_o = (hold_q && !is_echo(mode_i)) ? held_q : mode_i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= 1'b0;
               held_q <= MODE_NORMAL;
            end else if (rx_tick_i) begin
               hold_q <= is_echo(eff_mode_o) && stop_i && tx_en_i;
               held_q <= eff_mode_o;
            end
         end

         // R8: a pending exit lasts no longer than one bit time
         a_r8_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_tick_i && !stop_i) |=> !hold_q);
         // R9: no deferral without an enabled transmitter
         a_r9_no_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_tick_i && !tx_en_i) |=> !hold_q);
         // R8: while pending, routing stays in an echo mode
         a_r8_hold_is_echo: assert property (@(posedge clk) disable iff (!rst_n)
            hold_q |-> is_echo(eff_mode_o));
      end else begin : g_direct
         assign eff_mode_o = mode_i;
      end
   endgenerate
endmodule

// File: rtl/urt_route_decode.sv
module urt_route_decode
   import uart_route_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  chan_mode_e eff_mode_i,
   input  logic       rxd_i,
   input  logic       tx_ser_i,
   input  logic       echo_bit_i,
   input  logic       rx_tick_i,
   input  logic       tx_tick_i,
   output logic       txd_o,
   output logic       rx_ser_o,
   output logic       rx_tick_o,
   output logic       tx_tick_o,
   output logic       cpu_rx_en_o,
   output logic       cpu_tx_en_o,
   output logic       tx_stat_en_o,
   output logic       rx_err_en_o,
   output logic       rx_chk_en_o
);
   always_comb begin
      txd_o        = tx_ser_i;
      rx_ser_o     = rxd_i;
      rx_tick_o    = rx_tick_i;
      tx_tick_o    = tx_tick_i;
      cpu_rx_en_o  = 1'b1;
      cpu_tx_en_o  = 1'b1;
      tx_stat_en_o = 1'b1;
      rx_err_en_o  = 1'b1;
      rx_chk_en_o  = 1'b1;
      unique case (eff_mode_i)
         MODE_NORMAL: ;
         MODE_ECHO: begin
            txd_o        = echo_bit_i;
            tx_tick_o    = rx_tick_i;
            cpu_tx_en_o  = 1'b0;
            tx_stat_en_o = 1'b0;
         end
         MODE_LOCAL: begin
            txd_o     = 1'b1;
            rx_ser_o  = tx_ser_i;
            rx_tick_o = tx_tick_i;
         end
         MODE_REMOTE: begin
            txd_o        = echo_bit_i;
            tx_tick_o    = rx_tick_i;
            cpu_rx_en_o  = 1'b0;
            cpu_tx_en_o  = 1'b0;
            tx_stat_en_o = 1'b0;
            rx_err_en_o  = 1'b0;
            rx_chk_en_o  = 1'b0;
         end
         default: ;
      endcase
   end

   a_r1_normal_transparent: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == MODE_NORMAL) |-> (txd_o == tx_ser_i && rx_ser_o == rxd_i));
   a_r3_echo_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
      is_echo(eff_mode_i) |-> (!cpu_tx_en_o && !tx_stat_en_o));
   a_r4_local_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == MODE_LOCAL) |-> (txd_o && rx_ser_o == tx_ser_i));
   a_r5_remote_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == MODE_REMOTE) |-> (!cpu_rx_en_o && !rx_err_en_o && !rx_chk_en_o));
endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
   import uart_route_pkg::*;
#(
   parameter bit IDLE_LEVEL = 1'b1,
   parameter int DEFER_EXIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              rxd_i,
   input  logic              tx_ser_i,
   input  logic              rx_tick_i,
   input  logic              tx_tick_i,
   input  logic              tx_en_i,
   input  logic              rx_stop_i,
   output logic              txd_o,
   output logic              rx_ser_o,
   output logic              rx_tick_o,
   output logic              tx_tick_o,
   output logic              cpu_rx_en_o,
   output logic              cpu_tx_en_o,
   output logic              tx_stat_en_o,
   output logic              rx_err_en_o,
   output logic              rx_chk_en_o
);
   chan_mode_e req_mode;
   chan_mode_e eff_mode;
   logic       echo_bit;

   assign req_mode = chan_mode_e'(mode_i);

   urt_echo_retimer #(.IDLE_LEVEL(IDLE_LEVEL)) u_retime (
      .clk(clk), .rst_n(rst_n), .tick_i(rx_tick_i), .din_i(rxd_i), .dout_o(echo_bit)
   );

   urt_exit_holder #(.DEFER_EXIT(DEFER_EXIT)) u_exit (
      .clk(clk), .rst_n(rst_n), .mode_i(req_mode), .rx_tick_i(rx_tick_i),
      .stop_i(rx_stop_i), .tx_en_i(tx_en_i), .eff_mode_o(eff_mode)
   );

   urt_route_decode u_route (
      .clk(clk), .rst_n(rst_n), .eff_mode_i(eff_mode),
      .rxd_i(rxd_i), .tx_ser_i(tx_ser_i), .echo_bit_i(echo_bit),
      .rx_tick_i(rx_tick_i), .tx_tick_i(tx_tick_i),
      .txd_o(txd_o), .rx_ser_o(rx_ser_o), .rx_tick_o(rx_tick_o), .tx_tick_o(tx_tick_o),
      .cpu_rx_en_o(cpu_rx_en_o), .cpu_tx_en_o(cpu_tx_en_o), .tx_stat_en_o(tx_stat_en_o),
      .rx_err_en_o(rx_err_en_o), .rx_chk_en_o(rx_chk_en_o)
   );

   // R10: echo register starts at the idle line level
   a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && is_echo(eff_mode)) |-> (txd_o == IDLE_LEVEL));
endmodule

// File: tb/uart_mode_router_tb.sv
module uart_mode_router_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic rxd = 1'b1, txs = 1'b1, rxt = 1'b0, txt = 1'b0, txen = 1'b0, stp = 1'b0;
   logic txd, rxser, rxto, txto, crx, ctx, tst, rer, rch;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   uart_mode_router u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .rxd_i(rxd), .tx_ser_i(txs),
      .rx_tick_i(rxt), .tx_tick_i(txt), .tx_en_i(txen), .rx_stop_i(stp),
      .txd_o(txd), .rx_ser_o(rxser), .rx_tick_o(rxto), .tx_tick_o(txto),
      .cpu_rx_en_o(crx), .cpu_tx_en_o(ctx), .tx_stat_en_o(tst),
      .rx_err_en_o(rer), .rx_chk_en_o(rch)
   );

   // {mode, rxd, txs, rxt, txt, txd, rxser, rxto, txto, crx, ctx, tst, rer, rch}
   localparam logic [14:0] VEC [8] = '{
      {2'b00, 4'b0101, 9'b100111111},
      {2'b00, 4'b1010, 9'b011011111},
      {2'b01, 4'b0001, 9'b100010011},
      {2'b01, 4'b1010, 9'b111110011},
      {2'b10, 4'b0101, 9'b111111111},
      {2'b10, 4'b1010, 9'b100011111},
      {2'b11, 4'b0101, 9'b100000000},
      {2'b11, 4'b1110, 9'b111100000}
   };

   function automatic logic [8:0] outs();
      return {txd, rxser, rxto, txto, crx, ctx, tst, rer, rch};
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic next_drive();
      @(negedge clk);
   endtask

   task automatic settle();
      #5;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10: reset state, echo register idle high
      mode = 2'b01;
      rxd = 1'b0;
      repeat (3) @(posedge clk);
      settle();
      check("R10 txd in reset", {8'd0, txd}, 9'd1);
      next_drive();
      rst_n = 1'b1;
      settle();
      check("R10 txd after reset", {8'd0, txd}, 9'd1);
      rxd = 1'b1;

      // Table of routing vectors; rxd is 1 whenever rxt is 1
      foreach (VEC[i]) begin
         next_drive();
         {mode, rxd, txs, rxt, txt} = VEC[i][14:9];
         settle();
         case (VEC[i][14:13])
            2'b00: check("R1 normal routing", outs(), VEC[i][8:0]);
            2'b01: check("R3 echo routing", outs(), VEC[i][8:0]);
            2'b10: check("R4 local routing", outs(), VEC[i][8:0]);
            default: check("R5 remote routing", outs(), VEC[i][8:0]);
         endcase
      end

      // R2: echo re-clocking, value held between ticks
      next_drive();
      mode = 2'b01; rxt = 1'b1; rxd = 1'b0; txt = 1'b0;
      settle();
      check("R2 tx tick follows rx tick", {8'd0, txto}, 9'd1);
      check("R2 txd before tick edge", {8'd0, txd}, 9'd1);
      next_drive();
      rxt = 1'b0; rxd = 1'b1;
      settle();
      check("R2 txd after tick", {8'd0, txd}, 9'd0);
      next_drive();
      settle();
      check("R2 txd held without tick", {8'd0, txd}, 9'd0);
      next_drive();
      rxt = 1'b1;
      next_drive();
      rxt = 1'b0;
      settle();
      check("R2 txd reload high", {8'd0, txd}, 9'd1);

      // R6: break echoed in remote loopback
      next_drive();
      mode = 2'b11; rxd = 1'b0;
      for (int k = 0; k < 4; k++) begin
         rxt = 1'b1;
         next_drive();
         rxt = 1'b0;
         settle();
         check("R6 break echoed", {8'd0, txd}, 9'd0);
         next_drive();
      end

      // R7: immediate mode change, no clock edge needed
      mode = 2'b00; txs = 1'b1; txen = 1'b0;
      #2;
      check("R7 immediate to normal", {7'd0, txd, ctx}, 9'd3);
      mode = 2'b11;
      #2;
      check("R7 immediate to remote", {7'd0, txd, crx}, 9'd0);

      // R8: deferred exit from automatic echo
      next_drive();
      mode = 2'b01; rxd = 1'b1; txen = 1'b1; rxt = 1'b1; stp = 1'b1;
      next_drive();
      rxt = 1'b0; stp = 1'b0; mode = 2'b00; txs = 1'b0;
      settle();
      check("R8 exit deferred txd", {7'd0, txd, ctx}, 9'b10);
      repeat (3) next_drive();
      settle();
      check("R8 still deferred", {7'd0, txd, tst}, 9'b10);
      next_drive();
      rxt = 1'b1;
      next_drive();
      rxt = 1'b0;
      settle();
      check("R8 exit completes", {7'd0, txd, ctx}, 9'b01);

      // R8: deferred exit from remote loopback keeps CPU receive blocked
      next_drive();
      mode = 2'b11; rxt = 1'b1; stp = 1'b1;
      next_drive();
      rxt = 1'b0; stp = 1'b0; mode = 2'b10;
      settle();
      check("R8 remote exit deferred", {7'd0, crx, txd}, 9'b01);
      next_drive();
      rxt = 1'b1;
      next_drive();
      rxt = 1'b0;
      settle();
      check("R8 remote exit done", {7'd0, crx, rxser}, 9'b10);

      // R9: transmitter disabled at stop sample, exit is immediate
      next_drive();
      mode = 2'b01; txen = 1'b0; rxt = 1'b1; stp = 1'b1;
      next_drive();
      rxt = 1'b0; stp = 1'b0; mode = 2'b00; txs = 1'b0;
      settle();
      check("R9 no defer when disabled", {7'd0, txd, ctx}, 9'b01);

      // R9: no stop sample, exit is immediate even with transmitter enabled
      next_drive();
      mode = 2'b01; txen = 1'b1; rxt = 1'b1; stp = 1'b0;
      next_drive();
      rxt = 1'b0; mode = 2'b00;
      settle();
      check("R9 no defer without stop", {7'd0, txd, ctx}, 9'b01);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule